// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Generator

This block turns single-byte read and write requests into the chip-select, read-strobe and write-strobe waveforms an asynchronous 8-bit external memory needs, such as a NAND flash. Every access runs through three phases: setup, strobe and hold. A turnaround gap follows before the next access can start. The length of each phase is taken from one 32-bit configuration word, and a field value of N gives N+1 controller clocks. Reads and writes have their own setup, strobe and hold fields. The turnaround field is shared.

A request is accepted while `reqReady` is high. The block captures the timing fields, the write data and the command/address qualifiers in the cycle of acceptance. On a read, the byte on the memory data bus is sampled at the end of the strobe phase and returned with a one-cycle response pulse. The command and address latch-enable outputs follow the request qualifiers on writes only. A ready/busy pin from the memory is registered and reported as a status output.

Top module: `amemTimingGen`

## Requirements
- R1: After reset, `memCsN`, `memReN` and `memWeN` are high, `memCle`, `memAle`, `memDataOe` and `rspValid` are low, and `reqReady` is high when the configuration is supported.
- R2: Configuration fields, with a field value N giving N+1 clocks: turnaround is `cfgWord[3:2]`. Write timing is setup `[29:26]`, strobe `[25:20]` and hold `[19:17]`. Read timing is setup `[16:13]`, strobe `[12:7]` and hold `[6:4]`. A write uses only the write fields and a read uses only the read fields.
- R3: During an access, `memCsN` is low for exactly setup+strobe+hold clocks, in one contiguous run. The strobe is low only inside that run, after the setup clocks. `memWeN` pulses only on writes and `memReN` only on reads.
- R4: On a read, the value of `memDataIn` in the last strobe clock appears on `rspData` with `rspValid` high for exactly one clock, which is the first hold clock.
- R5: On a write, `memDataOe` is high and `memDataOut` equals the request byte in every clock where `memCsN` is low. `memDataOe` is low at all other times.
- R6: `memCle` and `memAle` equal `reqCmd` and `reqAddr` of a write request while `memCsN` is low. They stay low on reads and while idle.
- R7: After `memCsN` rises, `reqReady` stays low for exactly turnaround+1 clocks, with `memCsN` high, and then rises.
- R8: If `cfgWord[31]` or `cfgWord[30]` is set, or if `cfgWord[1:0]` is not 0 (0 meaning an 8-bit bus), `reqReady` is low and no access starts.
- R9: A change of `cfgWord` after a request is accepted does not alter the phase lengths of that access.
- R10: `devReady` equals `memRdy` as it was one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Timing and mode configuration word |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCmd | input | 1 | Write is a command cycle |
| reqAddr | input | 1 | Write is an address cycle |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Request accepted this clock when valid |
| rspValid | output | 1 | Read data pulse |
| rspData | output | 8 | Read byte |
| memCsN | output | 1 | Chip select, active low |
| memReN | output | 1 | Read strobe, active low |
| memWeN | output | 1 | Write strobe, active low |
| memCle | output | 1 | Command latch enable |
| memAle | output | 1 | Address latch enable |
| memDataOut | output | 8 | Data driven to memory |
| memDataOe | output | 1 | Output enable for memDataOut |
| memDataIn | input | 8 | Data returned by memory |
| memRdy | input | 1 | Memory ready/busy pin |
| devReady | output | 1 | Registered ready status |

## Verification
Two events share one clock edge on a read. The last strobe clock captures the data byte, and the same edge moves the sequencer from strobe to hold. A sample taken one clock early or late would still look plausible. To catch this, the bench changes `memDataIn` in every strobe clock, so only the correct capture clock gives the expected byte, and it requires the response in the first hold clock. A second collision is request acceptance against a configuration change. The bench rewrites `cfgWord` in the clock right after acceptance and checks that the phase lengths still follow the old word.

// File: rtl/amemPkg.sv
package amemPkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_TURN
  } phaseT;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // request accepted this clock
    logic active;   // chip select window
    logic strobe;   // strobe phase
    logic capture;  // last strobe clock
  } ctrlT;
endpackage

// File: rtl/amemCtrl.sv
module amemCtrl
  import amemPkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cfgWord,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlT        ctrl
);
  phaseT phase;
  logic [CNT_W-1:0] cnt, strobeLen, holdLen, turnLen;

  logic cfgOk;
  logic [CNT_W-1:0] wSetup, wStrobe, wHold, rSetup, rStrobe, rHold, taLen;

  assign cfgOk   = !cfgWord[31] && !cfgWord[30] && (cfgWord[1:0] == 2'b00);
  assign wSetup  = CNT_W'(cfgWord[29:26]);
  assign wStrobe = CNT_W'(cfgWord[25:20]);
  assign wHold   = CNT_W'(cfgWord[19:17]);
  assign rSetup  = CNT_W'(cfgWord[16:13]);
  assign rStrobe = CNT_W'(cfgWord[12:7]);
  assign rHold   = CNT_W'(cfgWord[6:4]);
  assign taLen   = CNT_W'(cfgWord[3:2]);

  assign reqReady = (phase == PH_IDLE) && cfgOk;

  always_comb begin
    ctrl.load    = reqValid && reqReady;
    ctrl.active  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ctrl.strobe  = (phase == PH_STROBE);
    ctrl.capture = (phase == PH_STROBE) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      strobeLen <= '0;
      holdLen   <= '0;
      turnLen   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (ctrl.load) begin
          phase     <= PH_SETUP;
          cnt       <= reqWrite ? wSetup  : rSetup;
          strobeLen <= reqWrite ? wStrobe : rStrobe;
          holdLen   <= reqWrite ? wHold   : rHold;
          turnLen   <= taLen;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= strobeLen;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= holdLen;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          phase <= PH_TURN;
          cnt   <= turnLen;
        end else cnt <= cnt - 1'b1;
        PH_TURN: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amemDatapath.sv
module amemDatapath
  import amemPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic              reqWrite,
  input  logic              reqCmd,
  input  logic              reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDataIn,
  input  logic              memRdy,
  output logic              memCsN,
  output logic              memReN,
  output logic              memWeN,
  output logic              memCle,
  output logic              memAle,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              devReady
);
  logic wrQ, cmdQ, addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ      <= 1'b0;
      cmdQ     <= 1'b0;
      addrQ    <= 1'b0;
      dataQ    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      devReady <= 1'b0;
    end else begin
      if (ctrl.load) begin
        wrQ   <= reqWrite;
        cmdQ  <= reqCmd;
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      rspValid <= ctrl.capture && !wrQ;
      if (ctrl.capture && !wrQ) rspData <= memDataIn;
      devReady <= memRdy;
    end
  end

  assign memCsN     = !ctrl.active;
  assign memReN     = !(ctrl.strobe && !wrQ);
  assign memWeN     = !(ctrl.strobe && wrQ);
  assign memCle     = ctrl.active && wrQ && cmdQ;
  assign memAle     = ctrl.active && wrQ && addrQ;
  assign memDataOe  = ctrl.active && wrQ;
  assign memDataOut = dataQ;
endmodule

// File: rtl/amemTimingGen.sv
module amemTimingGen
  import amemPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgWord,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqCmd,
  input  logic              reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCsN,
  output logic              memReN,
  output logic              memWeN,
  output logic              memCle,
  output logic              memAle,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  input  logic              memRdy,
  output logic              devReady
);
  ctrlT ctrl;

  amemCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqReady(reqReady), .ctrl(ctrl)
  );

  amemDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqWrite(reqWrite), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDataIn(memDataIn), .memRdy(memRdy),
    .memCsN(memCsN), .memReN(memReN), .memWeN(memWeN), .memCle(memCle),
    .memAle(memAle), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .rspValid(rspValid), .rspData(rspData), .devReady(devReady)
  );
endmodule

// File: rtl/amemTimingGen_sva.sv
module amemTimingGen_sva (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] cfgWord,
  input logic        reqReady,
  input logic        rspValid,
  input logic        memCsN,
  input logic        memReN,
  input logic        memWeN,
  input logic        memCle,
  input logic        memAle,
  input logic        memDataOe
);
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!memReN || !memWeN) |-> !memCsN);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!memReN && !memWeN));
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!memReN) && memReN);
  a_r5_oe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> !memCsN);
  a_r6_latch_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (memCle || memAle) |-> memDataOe);
  a_r7_turn_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCsN) |-> !reqReady);
  a_r8_bad_cfg: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[31] || cfgWord[30] || cfgWord[1:0] != 2'b00) |-> !reqReady);
endmodule

bind amemTimingGen amemTimingGen_sva u_sva (
  .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .reqReady(reqReady),
  .rspValid(rspValid), .memCsN(memCsN), .memReN(memReN), .memWeN(memWeN),
  .memCle(memCle), .memAle(memAle), .memDataOe(memDataOe)
);

// File: tb/amemTimingGen_tb.sv
`timescale 1ns/1ps
module amemTimingGen_tb;
  logic clk = 0;
  logic rstN = 0;
  logic [31:0] cfgWord;
  logic reqValid = 0, reqWrite = 0, reqCmd = 0, reqAddr = 0;
  logic [7:0] reqWdata = 0;
  logic reqReady, rspValid, memCsN, memReN, memWeN, memCle, memAle, memDataOe, devReady;
  logic [7:0] rspData, memDataOut;
  logic [7:0] memDataIn = 0;
  logic memRdy = 0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  amemTimingGen u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(int ws, int wt, int wh, int rs, int rt, int rh, int ta);
    return (32'(ws) << 26) | (32'(wt) << 20) | (32'(wh) << 17) |
           (32'(rs) << 13) | (32'(rt) << 7) | (32'(rh) << 4) | (32'(ta) << 2);
  endfunction

  // one access; e* are field values (N means N+1 clocks)
  task automatic access(input bit wr, input bit cmd, input bit adr, input logic [7:0] wd,
                        input logic [7:0] base, input int eS, input int eT, input int eH,
                        input int eTa, input logic [31:0] newCfg, input bit swapCfg);
    int sC = 0, tC = 0, hC = 0, taC = 0, rspN = 0, guard = 0;
    bit csErr = 0, qErr = 0, dErr = 0, wrongStrobe = 0, rspOk = 1, gapCs = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqCmd = cmd; reqAddr = adr; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0; reqWdata = ~wd; reqCmd = ~cmd; reqAddr = ~adr;
    if (swapCfg) cfgWord = newCfg;
    forever begin
      bit sLow, oLow;
      sLow = wr ? !memWeN : !memReN;
      oLow = wr ? !memReN : !memWeN;
      if (oLow) wrongStrobe = 1;
      if (!memCsN) begin
        if (taC != 0) gapCs = 1;
        if (sLow) begin
          if (hC != 0) csErr = 1;
          tC++;
          memDataIn = base + 8'(tC);
        end else if (tC == 0) sC++;
        else hC++;
        if (memCle !== (wr & cmd) || memAle !== (wr & adr)) qErr = 1;
        if (wr && (!memDataOe || memDataOut !== wd)) dErr = 1;
        if (!wr && memDataOe) dErr = 1;
      end else begin
        if (sLow) csErr = 1;
        if (memCle || memAle || memDataOe) qErr = 1;
        if (reqReady && sC + tC + hC > 0) break;
        taC++;
      end
      if (rspValid) begin
        rspN++;
        if (wr || hC != 1 || rspData !== base + 8'(eT + 1)) rspOk = 0;
      end
      guard++;
      if (guard > 400) break;
      @(negedge clk);
    end
    chk(sC == eS + 1, wr ? "R2/R3 write setup" : "R2/R3 read setup", sC, eS + 1);
    chk(tC == eT + 1, wr ? "R2/R3 write strobe" : "R2/R3 read strobe", tC, eT + 1);
    chk(hC == eH + 1, wr ? "R2/R3 write hold" : "R2/R3 read hold", hC, eH + 1);
    chk(taC == eTa + 1 && !gapCs, "R7 turnaround", taC, eTa + 1);
    chk(!csErr && !wrongStrobe, "R3 strobe placement", int'(csErr) + int'(wrongStrobe), 0);
    chk(!qErr, "R6 latch enables", qErr, 0);
    chk(!dErr, "R5 write data window", dErr, 0);
    chk(rspOk && rspN == (wr ? 0 : 1), "R4 read capture", rspN, wr ? 0 : 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfgWord = mkCfg(1, 3, 1, 1, 5, 1, 3);
    repeat (3) @(negedge clk);
    chk(memCsN && memReN && memWeN, "R1 strobes idle", {memCsN, memReN, memWeN}, 7);
    chk(!memCle && !memAle && !memDataOe && !rspValid, "R1 outputs low",
        {memCle, memAle, memDataOe, rspValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(reqReady, "R1 ready after reset", reqReady, 1);

    // R2 R3 R4 R5 R6 R7 sweep
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 4; t++)
        for (int h = 0; h < 3; h++)
          for (int ta = 0; ta < 4; ta++)
            for (int w = 0; w < 2; w++) begin
              if (w == 1) cfgWord = mkCfg(s, t, h, 2 - s, 3 - t, 2 - h, ta);
              else        cfgWord = mkCfg(2 - s, 3 - t, 2 - h, s, t, h, ta);
              access(w[0], t[0], h[0], 8'(16 * s + t + 7 * h + w), 8'(40 + 5 * s + h),
                     s, t, h, ta, 0, 0);
            end

    // R9: cfg rewritten right after acceptance
    cfgWord = mkCfg(1, 2, 1, 1, 2, 1, 1);
    access(1, 1, 0, 8'hA5, 8'h10, 1, 2, 1, 1, mkCfg(3, 7, 4, 3, 7, 4, 3), 1);
    cfgWord = mkCfg(0, 1, 0, 0, 1, 0, 0);
    access(0, 0, 1, 8'h00, 8'h20, 0, 1, 0, 0, mkCfg(5, 9, 6, 5, 9, 6, 2), 1);

    // R8: unsupported modes
    for (int m = 0; m < 3; m++) begin
      int csSeen = 0, rdySeen = 0;
      @(negedge clk);
      cfgWord = mkCfg(1, 1, 1, 1, 1, 1, 0);
      if (m == 0) cfgWord[31] = 1;
      else if (m == 1) cfgWord[30] = 1;
      else cfgWord[1:0] = 2'b01;
      reqValid = 1; reqWrite = 1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!memCsN) csSeen++;
        if (reqReady) rdySeen++;
      end
      reqValid = 0;
      chk(csSeen == 0 && rdySeen == 0, "R8 unsupported config", csSeen + rdySeen, 0);
    end
    cfgWord = mkCfg(1, 1, 1, 1, 1, 1, 0);
    @(negedge clk);
    chk(reqReady, "R8 ready restored", reqReady, 1);

    // R10: ready pin status
    memRdy = 1;
    chk(!devReady, "R10 status lag", devReady, 0);
    @(negedge clk);
    chk(devReady, "R10 status high", devReady, 1);
    memRdy = 0;
    @(negedge clk);
    chk(!devReady, "R10 status low", devReady, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule